// File: doc/BRIEF.md
# Interrupt Acknowledge and Priority Stack

This block is the acknowledge half of a prioritized interrupt controller serving one processor. An external arbiter hands it the winning pending request as a vector number and a priority. The block compares that priority with the current priority and raises a request to the processor. The acknowledge arrives in one of two ways. In software-vector mode, software reads an acknowledge register. In hardware-vector mode, the processor pulses an acknowledge pin, and the vector has already been presented on a dedicated output bus.

Every acknowledge saves the running priority on a small last-in-first-out stack and raises the current priority to that of the acknowledged source. A write to the end-of-interrupt register restores the saved level. If an acknowledge and an end-of-interrupt fall in the same cycle, the block takes the new priority and leaves the stack as it is.

Software reaches the block through a four-entry register port with single-cycle read and write strobes. Read data is registered and appears one cycle after the read strobe. Debug operation needs no special handling, because behaviour is the same in every operating state.

Top module: `irq_ack_core`

## Requirements
- R1: After reset, `irq_req` is 0, `irq_vec` is 0, `hw_vec_en` is 0, `cur_prio` is 0, and a read of the status register (address 3) returns 0.
- R2: Bit 0 of the control register (address 2'd0) selects the mode: 0 is software-vector, 1 is hardware-vector. `hw_vec_en` shows that bit one cycle after the write.
- R3: While `irq_req` is low, it rises one cycle after a cycle in which `win_valid` is 1 and `win_prio` is strictly greater than `cur_prio`. An equal or lower priority leaves it low.
- R4: In software-vector mode, a read of address 2'd1 while `irq_req` is high acknowledges the request. The vector latched when the request rose appears on `reg_rdata` in the next cycle. `cpu_ack` has no effect, and `irq_vec` is held at zero.
- R5: In hardware-vector mode, `irq_vec` takes the winning vector in the same cycle that `irq_req` rises. A one-cycle `cpu_ack` pulse acknowledges the request. A read of address 2'd1 returns the vector but does not acknowledge.
- R6: After an acknowledge, `irq_req` is low for at least one cycle, even when a higher-priority request is already waiting.
- R7: An acknowledge pushes `cur_prio` onto the stack, and `cur_prio` then becomes the acknowledged source's priority, visible one cycle later.
- R8: Any write to address 2'd2 (end-of-interrupt) pops the stack top into `cur_prio`. A pop of an empty stack sets `cur_prio` to 0.
- R9: An acknowledge and an end-of-interrupt in the same cycle set `cur_prio` to the acknowledged priority and neither push nor pop the stack.
- R10: A push onto a full stack overwrites the top entry and sets a sticky overflow flag. The flag is read in bit `DATA_W-1` of the status register; bits `PRIO_W-1:0` of that register hold `cur_prio`.
- R11: An acknowledge (pin or register read) that arrives while `irq_req` is low changes nothing, and a read of address 2'd1 then returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_valid | input | 1 | The arbiter has a pending winner |
| win_vec | input | VEC_W | Vector number of the winner |
| win_prio | input | PRIO_W | Priority of the winner |
| cpu_ack | input | 1 | Processor acknowledge pulse (hardware-vector mode) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data, valid one cycle after `reg_rd` |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W | Vector for hardware-vector delivery, zero in software-vector mode |
| hw_vec_en | output | 1 | High when hardware-vector mode is selected |
| cur_prio | output | PRIO_W | Current running priority |

## Verification
A corrupted stack entry or depth count does not show up straight away. It appears only when a later end-of-interrupt restores the wrong level on `cur_prio`. It then shows up a second time, when `irq_req` rises or fails to rise against that level. For this reason the bench nests acknowledges and unwinds them, so that every stored level is read back. A wrong latched vector or priority appears at the next acknowledge, either on `reg_rdata` or on `cur_prio` one cycle later. A missed hold-off appears as `irq_req` staying high in the cycle right after the acknowledge.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int REG_ADDR_W = 2;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_ACK  = 2'd1,
    RA_EOI  = 2'd2,
    RA_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH  = 16,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [PRIO_W-1:0] push_val,
  output logic [PRIO_W-1:0] top_val,
  output logic              ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [PRIO_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  top_idx;

  assign top_idx = count - ONE;
  assign top_val = (count == '0) ? '0 : mem[top_idx[IDX_W-1:0]];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) begin
      if (count == FULL) mem[DEPTH-1] <= push_val;
      else               mem[count[IDX_W-1:0]] <= push_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (count == FULL) ovf <= 1'b1;
      else               count <= count + ONE;
    end else if (pop) begin
      if (count != '0) count <= count - ONE;
    end
  end

  // R9
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst) !(push && pop));
  // R7
  push_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (push && count != FULL) |=> count == $past(count) + ONE);
  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && count == '0) |=> count == '0);
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst) ovf |=> ovf);
endmodule

// File: rtl/req_ctrl.sv
module req_ctrl #(
  parameter int VEC_W  = 8,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_mode,
  input  logic              win_valid,
  input  logic [VEC_W-1:0]  win_vec,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              ack,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [VEC_W-1:0]  lat_vec,
  output logic [PRIO_W-1:0] lat_prio
);
  logic set_req;

  assign set_req = !irq_req && win_valid && (win_prio > cur_prio);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      lat_vec  <= '0;
      lat_prio <= '0;
    end else if (ack) begin
      irq_req <= 1'b0;
    end else if (set_req) begin
      irq_req  <= 1'b1;
      lat_vec  <= win_vec;
      lat_prio <= win_prio;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          irq_vec <= '0;
    else if (!hw_mode) irq_vec <= '0;
    else if (set_req)  irq_vec <= win_vec;
  end

  // R3
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(win_valid && (win_prio > cur_prio)));
  // R6
  req_gap_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !irq_req);
  // R4
  sw_vec_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hw_mode |=> irq_vec == '0);
  // R5
  hw_vec_load_chk: assert property (@(posedge clk) disable iff (rst)
    (hw_mode && $rose(irq_req)) |-> irq_vec == lat_vec);
endmodule

// File: rtl/reg_port.sv
module reg_port
  import irq_ack_pkg::*;
#(
  parameter int VEC_W  = 8,
  parameter int PRIO_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  input  logic                  irq_req,
  input  logic [VEC_W-1:0]      lat_vec,
  input  logic [PRIO_W-1:0]     cur_prio,
  input  logic                  stk_ovf,
  output logic                  hw_mode,
  output logic                  ack_rd,
  output logic                  eoi_wr,
  output logic [DATA_W-1:0]     reg_rdata
);
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rd_mux;

  assign hw_mode = ctrl_q[0];
  assign ack_rd  = reg_rd && (reg_addr_e'(reg_addr) == RA_ACK);
  assign eoi_wr  = reg_wr && (reg_addr_e'(reg_addr) == RA_EOI);

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(reg_addr))
      RA_CTRL: rd_mux = ctrl_q;
      RA_ACK:  if (irq_req) rd_mux[VEC_W-1:0] = lat_vec;
      RA_STAT: begin
        rd_mux[PRIO_W-1:0] = cur_prio;
        rd_mux[DATA_W-1]   = stk_ovf;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && (reg_addr_e'(reg_addr) == RA_CTRL)) ctrl_q <= reg_wdata;
      reg_rdata <= reg_rd ? rd_mux : '0;
    end
  end

  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd0) |=> hw_mode == $past(reg_wdata[0]));
endmodule

// File: rtl/irq_ack_core.sv
module irq_ack_core #(
  parameter int VEC_W      = 8,
  parameter int PRIO_W     = 4,
  parameter int DATA_W     = 8,
  parameter int LIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  logic [VEC_W-1:0]  win_vec,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              cpu_ack,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              hw_vec_en,
  output logic [PRIO_W-1:0] cur_prio
);
  logic              hw_mode;
  logic              ack_rd;
  logic              eoi_wr;
  logic              ack_evt;
  logic              push;
  logic              pop;
  logic [PRIO_W-1:0] top_val;
  logic              stk_ovf;
  logic [VEC_W-1:0]  lat_vec;
  logic [PRIO_W-1:0] lat_prio;

  assign ack_evt   = irq_req && (hw_mode ? cpu_ack : ack_rd);
  assign push      = ack_evt && !eoi_wr;
  assign pop       = eoi_wr && !ack_evt;
  assign hw_vec_en = hw_mode;

  reg_port #(.VEC_W(VEC_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_req(irq_req), .lat_vec(lat_vec), .cur_prio(cur_prio),
    .stk_ovf(stk_ovf), .hw_mode(hw_mode), .ack_rd(ack_rd), .eoi_wr(eoi_wr),
    .reg_rdata(reg_rdata)
  );

  req_ctrl #(.VEC_W(VEC_W), .PRIO_W(PRIO_W)) u_req (
    .clk(clk), .rst(rst), .hw_mode(hw_mode), .win_valid(win_valid), .win_vec(win_vec),
    .win_prio(win_prio), .cur_prio(cur_prio), .ack(ack_evt), .irq_req(irq_req),
    .irq_vec(irq_vec), .lat_vec(lat_vec), .lat_prio(lat_prio)
  );

  prio_lifo #(.DEPTH(LIFO_DEPTH), .PRIO_W(PRIO_W)) u_lifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_val(cur_prio),
    .top_val(top_val), .ovf(stk_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst)          cur_prio <= '0;
    else if (ack_evt) cur_prio <= lat_prio;
    else if (eoi_wr)  cur_prio <= top_val;
  end

  // R9
  collide_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_evt && eoi_wr) |=> cur_prio == $past(lat_prio));
  // R11
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && !eoi_wr) |=> cur_prio == $past(cur_prio));
  // R4
  sw_pin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!hw_mode && irq_req && !ack_rd && !eoi_wr) |=> irq_req && cur_prio == $past(cur_prio));
endmodule

// File: tb/test_irq_ack_core.sv
module test_irq_ack_core;
  localparam int CLK_PERIOD = 10;
  localparam int S_IRQ = 0, S_VEC = 1, S_CUR = 2, S_RD = 3, S_HWEN = 4;

  typedef struct {
    int    cyc;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       win_valid = 1'b0;
  logic [7:0] win_vec = '0;
  logic [3:0] win_prio = '0;
  logic       cpu_ack = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [7:0] irq_vec;
  logic       hw_vec_en;
  logic [3:0] cur_prio;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  exp_t sb[$];

  irq_ack_core #(.VEC_W(8), .PRIO_W(4), .DATA_W(8), .LIFO_DEPTH(4)) i_irq_ack_core (
    .clk(clk), .rst(rst), .win_valid(win_valid), .win_vec(win_vec), .win_prio(win_prio),
    .cpu_ack(cpu_ack), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .hw_vec_en(hw_vec_en), .cur_prio(cur_prio)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int sample(int sig);
    case (sig)
      S_IRQ:   return int'(irq_req);
      S_VEC:   return int'(irq_vec);
      S_CUR:   return int'(cur_prio);
      S_RD:    return int'(reg_rdata);
      default: return int'(hw_vec_en);
    endcase
  endfunction

  // monitor: compares every queued expectation due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        checks++;
        if (sample(sb[i].sig) != sb[i].val) begin
          errors++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%0h expected=%0h",
                   sb[i].tag, sb[i].sig, cyc, sample(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expect_v(int sig, int val, int dly, string tag);
    exp_t e;
    e.cyc = cyc + dly; e.sig = sig; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_rd(logic [1:0] a, int val, string tag);
    reg_rd = 1'b1; reg_addr = a;
    expect_v(S_RD, val, 1, tag);
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic do_wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    expect_v(S_IRQ, 0, 0, "R1"); expect_v(S_VEC, 0, 0, "R1");
    expect_v(S_CUR, 0, 0, "R1"); expect_v(S_HWEN, 0, 0, "R1");
    do_rd(2'd3, 0, "R1");

    // R3 equal priority does not request
    win_valid = 1'b1; win_prio = 4'd0; win_vec = 8'h05;
    expect_v(S_IRQ, 0, 1, "R3");
    tick();
    win_prio = 4'd3; win_vec = 8'h21;
    expect_v(S_IRQ, 1, 1, "R3"); expect_v(S_VEC, 0, 1, "R4");
    tick();
    // R4 pin ignored in software mode
    cpu_ack = 1'b1;
    expect_v(S_IRQ, 1, 1, "R4"); expect_v(S_CUR, 0, 1, "R4");
    tick();
    cpu_ack = 1'b0;
    // R4/R6/R7 register acknowledge with higher request waiting
    win_prio = 4'd5; win_vec = 8'h30;
    expect_v(S_CUR, 3, 1, "R7"); expect_v(S_IRQ, 0, 1, "R6"); expect_v(S_IRQ, 1, 2, "R6");
    do_rd(2'd1, 8'h21, "R4");
    tick();

    // R2 switch to hardware mode
    expect_v(S_HWEN, 1, 1, "R2");
    do_wr(2'd0, 8'h01);
    // R5 pin acknowledge
    cpu_ack = 1'b1;
    expect_v(S_IRQ, 0, 1, "R5"); expect_v(S_CUR, 5, 1, "R7");
    tick();
    cpu_ack = 1'b0;
    win_prio = 4'd9; win_vec = 8'h44;
    expect_v(S_IRQ, 1, 1, "R5"); expect_v(S_VEC, 8'h44, 1, "R5");
    tick();
    expect_v(S_IRQ, 1, 1, "R5"); expect_v(S_CUR, 5, 1, "R5");
    do_rd(2'd1, 8'h44, "R5");

    // R9 collision: stack holds 0,3 and must stay so
    cpu_ack = 1'b1; win_valid = 1'b0;
    expect_v(S_CUR, 9, 1, "R9"); expect_v(S_IRQ, 0, 1, "R9");
    do_wr(2'd2, 8'h00);
    cpu_ack = 1'b0;
    expect_v(S_CUR, 3, 1, "R9");
    do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 0, 1, "R8");
    do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 0, 1, "R8");
    do_wr(2'd2, 8'h00);

    // R11 acknowledge with no request
    cpu_ack = 1'b1;
    expect_v(S_CUR, 0, 1, "R11"); expect_v(S_IRQ, 0, 1, "R11");
    tick();
    cpu_ack = 1'b0;
    do_rd(2'd1, 0, "R11");

    // R8 empty pop with nonzero current priority
    win_valid = 1'b1; win_prio = 4'd2; win_vec = 8'h07;
    tick();
    cpu_ack = 1'b1; win_valid = 1'b0;
    expect_v(S_CUR, 2, 1, "R9");
    do_wr(2'd2, 8'h00);
    cpu_ack = 1'b0;
    expect_v(S_CUR, 0, 1, "R8");
    do_wr(2'd2, 8'h00);

    // R10 overflow with a four-entry stack
    do_rd(2'd3, 8'h00, "R10");
    for (int p = 1; p <= 5; p++) begin
      win_valid = 1'b1; win_prio = 4'(p); win_vec = 8'(p + 8'h60);
      expect_v(S_VEC, p + 8'h60, 1, "R5");
      tick();
      cpu_ack = 1'b1;
      expect_v(S_CUR, p, 1, "R7");
      tick();
      cpu_ack = 1'b0;
    end
    win_valid = 1'b0;
    do_rd(2'd3, 8'h85, "R10");
    expect_v(S_CUR, 4, 1, "R10"); do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 2, 1, "R10"); do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 1, 1, "R8");  do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 0, 1, "R8");  do_wr(2'd2, 8'h00);
    expect_v(S_CUR, 0, 1, "R8");  do_wr(2'd2, 8'h00);
    do_rd(2'd3, 8'h80, "R10");

    // R2/R4 back to software mode
    expect_v(S_HWEN, 0, 1, "R2"); expect_v(S_VEC, 0, 2, "R4");
    do_wr(2'd0, 8'h00);

    repeat (4) tick();
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending items", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule